// File: doc/BRIEF.md
# Disk Record Sequencer

This block keeps track of the record inside a disk sector that the controller is handling, and gives the microcode a 2-bit branch code that says whether to read, check or write that record. A load strobe takes a 16-bit command word from the bus and returns the record counter to its first state. Each increment strobe moves the counter to the next record. The counter follows a twisted-ring order rather than counting in binary.

Each of the three records takes its own 2-bit operation field from the stored command word. One counter state stands for no record and always gives the read code. If an increment arrives in that last state, the counter goes back to the start and a one-cycle overrun pulse is raised. Both outputs are driven by combinational logic from registered state only.

Top module: `disk_rec_seq`

## Requirements
- R1: After reset asserts (rst_ni low), cmd_o is 0, rec_o is 0, branch_o reflects the operation field for record 0 of a zero word (0), and ovr_o is 0.
- R2: When load_i is high at a rising clock edge, cmd_o takes bus_i and rec_o becomes 0 after that edge.
- R3: When inc_i is high and load_i is low at an edge, rec_o advances 0→1, 1→3, 3→2, 2→0. When both strobes are low, rec_o and cmd_o hold their values.
- R4: When load_i and inc_i are high in the same cycle, the load takes effect and the increment is discarded, so rec_o becomes 0.
- R5: The operation field maps to the branch code as follows: 0→0 (read), 1→2 (check), 2→3 (write), 3→3 (write).
- R6: In rec_o=0 (header), the field is cmd_o[7:6]. In rec_o=1 (label), it is cmd_o[5:4]. In rec_o=3 (data), it is cmd_o[3:2]. Here index 0 is the least significant bit.
- R7: In rec_o=2, branch_o is 0 whatever the value of cmd_o.
- R8: ovr_o is 1 for exactly the one cycle that follows an edge at which an increment, without a load, was applied in rec_o=2. Otherwise ovr_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Capture bus_i and restart the record sequence |
| inc_i | input | 1 | Move to the next record |
| bus_i | input | 16 | Command word source |
| cmd_o | output | 16 | Stored command word |
| rec_o | output | 2 | Current record number |
| branch_o | output | 2 | Branch code for the current record |
| ovr_o | output | 1 | One-cycle pulse after an increment in state 2 |

## Verification
The assertions assume that strobes change only between clock edges and that reset is applied at time zero. They also assume that an increment in state 2 is a legitimate event that the block must report, not an illegal input. The stimulus loads a range of command words that cover every field value. It walks the full ring, including wraps past state 2. It also applies load and increment together and leaves idle gaps. Strobes are driven on the falling edge so that they are stable at each rising edge.

// File: rtl/disk_rec_pkg.sv
package disk_rec_pkg;
  localparam int unsigned CMD_W = 16;
  localparam int unsigned REC_W = 2;
  localparam int unsigned OP_W  = 2;

  typedef enum logic [REC_W-1:0] {
    REC_HDR  = 2'd0,
    REC_LBL  = 2'd1,
    REC_IDLE = 2'd2,
    REC_DAT  = 2'd3
  } rec_e;

  localparam int unsigned HDR_LSB = 6;
  localparam int unsigned LBL_LSB = 4;
  localparam int unsigned DAT_LSB = 2;

  localparam logic [OP_W-1:0] BR_READ  = 2'd0;
  localparam logic [OP_W-1:0] BR_CHECK = 2'd2;
  localparam logic [OP_W-1:0] BR_WRITE = 2'd3;
endpackage

// File: rtl/disk_rec_ring.sv
module disk_rec_ring
  import disk_rec_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             inc_i,
  output logic [REC_W-1:0] rec_o,
  output logic             ovr_o
);
  logic [REC_W-1:0] rec_q;
  logic             ovr_q;
  logic             step;

  assign step = inc_i && !load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rec_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      ovr_q <= step && (rec_q == REC_IDLE);
      if (load_i)    rec_q <= '0;
      else if (step) rec_q <= {rec_q[0], ~rec_q[1]};  // twisted ring
    end
  end

  assign rec_o = rec_q;
  assign ovr_o = ovr_q;

  p_load_clears_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> rec_q == '0);
  p_ring_order_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && rec_q == REC_HDR) |=> rec_q == REC_LBL);
  p_ring_dat_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && rec_q == REC_LBL) |=> rec_q == REC_DAT);
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !inc_i) |=> $stable(rec_q));
  p_load_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && inc_i) |=> rec_q == REC_HDR);
  p_ovr_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_q |-> $past(rec_q) == REC_IDLE);
endmodule

// File: rtl/disk_rec_cmd.sv
module disk_rec_cmd
  import disk_rec_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CMD_W-1:0] bus_i,
  output logic [CMD_W-1:0] cmd_o
);
  logic [CMD_W-1:0] cmd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cmd_q <= '0;
    else if (load_i) cmd_q <= bus_i;
  end

  assign cmd_o = cmd_q;

  p_cmd_capture_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cmd_q == $past(bus_i));
  p_cmd_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(cmd_q));
endmodule

// File: rtl/disk_rec_branch.sv
module disk_rec_branch
  import disk_rec_pkg::*;
(
  input  logic [CMD_W-1:0] cmd_i,
  input  logic [REC_W-1:0] rec_i,
  output logic [OP_W-1:0]  branch_o
);
  logic [OP_W-1:0] field;
  logic            none;

  always_comb begin
    none = 1'b0;
    unique case (rec_e'(rec_i))
      REC_HDR: field = cmd_i[HDR_LSB +: OP_W];
      REC_LBL: field = cmd_i[LBL_LSB +: OP_W];
      REC_DAT: field = cmd_i[DAT_LSB +: OP_W];
      default: begin field = '0; none = 1'b1; end
    endcase
  end

  always_comb begin
    if (none) branch_o = BR_READ;
    else begin
      unique case (field)
        2'd0:    branch_o = BR_READ;
        2'd1:    branch_o = BR_CHECK;
        default: branch_o = BR_WRITE;
      endcase
    end
  end

  always_comb begin
    if (rec_i == REC_IDLE) a_idle_read_r7: assert (branch_o == BR_READ);
    a_never_one_r5: assert (branch_o != 2'd1);
  end
endmodule

// File: rtl/disk_rec_seq.sv
module disk_rec_seq
  import disk_rec_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        load_i,
  input  logic        inc_i,
  input  logic [15:0] bus_i,
  output logic [15:0] cmd_o,
  output logic [1:0]  rec_o,
  output logic [1:0]  branch_o,
  output logic        ovr_o
);
  disk_rec_cmd u_cmd (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .bus_i(bus_i), .cmd_o(cmd_o)
  );
  disk_rec_ring u_ring (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .inc_i(inc_i),
    .rec_o(rec_o), .ovr_o(ovr_o)
  );
  disk_rec_branch u_br (
    .cmd_i(cmd_o), .rec_i(rec_o), .branch_o(branch_o)
  );

  p_ovr_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o |-> rec_o == REC_HDR);
  p_hdr_field_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_o == REC_HDR && cmd_o[7:6] == 2'd0) |-> branch_o == 2'd0);
endmodule

// File: tb/disk_rec_seq_bench.sv
module disk_rec_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0, inc = 1'b0;
  logic [15:0] bus = '0;
  logic [15:0] cmd;
  logic [1:0]  rec, br;
  logic        ovr;

  int checks = 0, fails = 0;
  int m_rec = 0, m_cmd = 0, m_ovr = 0;
  int order[$] = '{0, 1, 3, 2};

  always #(CLK_PERIOD/2) clk = ~clk;

  disk_rec_seq u_disk_rec_seq (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .inc_i(inc), .bus_i(bus),
    .cmd_o(cmd), .rec_o(rec), .branch_o(br), .ovr_o(ovr)
  );

  function automatic int op_map(int f);
    if (f == 0) return 0;
    if (f == 1) return 2;
    return 3;
  endfunction

  function automatic int exp_branch(int c, int r);
    case (r)
      0: return op_map((c / 64) % 4);
      1: return op_map((c / 16) % 4);
      3: return op_map((c / 4) % 4);
      default: return 0;
    endcase
  endfunction

  function automatic int next_rec(int r);
    for (int i = 0; i < 4; i++) if (order[i] == r) return order[(i + 1) % 4];
    return 0;
  endfunction

  task automatic check(string req);
    checks++;
    if (int'(rec) != m_rec || int'(cmd) != m_cmd || int'(ovr) != m_ovr ||
        int'(br) != exp_branch(m_cmd, m_rec)) begin
      fails++;
      $display("FAIL %s rec=%0d/%0d cmd=%h/%h ovr=%0d/%0d br=%0d/%0d", req,
               rec, m_rec, cmd, m_cmd[15:0], ovr, m_ovr, br, exp_branch(m_cmd, m_rec));
    end
  endtask

  // drive on negedge, update model, compare at next negedge
  task automatic step(bit ld, bit in, logic [15:0] b, string req);
    @(negedge clk);
    load = ld; inc = in; bus = b;
    @(posedge clk);
    m_ovr = (in && !ld && m_rec == 2) ? 1 : 0;
    if (ld) begin m_cmd = int'(b); m_rec = 0; end
    else if (in) m_rec = next_rec(m_rec);
    @(negedge clk);
    load = 0; inc = 0;
    check(req);
  endtask

  initial begin
    #1;
    check("R1");
    #(CLK_PERIOD*2);
    check("R1");
    rst_n = 1'b1;
    // field sweep: every op value in each record slot (R5, R6)
    for (int v = 0; v < 4; v++) begin
      logic [15:0] w;
      w = 16'hA503 ^ 16'({v[1:0], v[1:0]^2'd1, (~v[1:0])} << 2);
      step(1, 0, w, "R2");
      step(0, 0, 16'hFFFF, "R3_hold");
      step(0, 1, 16'h0, "R6_lbl");
      step(0, 1, 16'h0, "R6_dat");
      step(0, 1, 16'h0, "R7");
      step(0, 1, 16'h0, "R8");
      step(0, 0, 16'h0, "R8_clear");
    end
    step(1, 0, 16'h00FC, "R5");
    step(0, 1, 16'h0, "R5");
    step(0, 1, 16'h0, "R5");
    step(0, 1, 16'h0, "R7");
    step(1, 1, 16'h0010, "R4");
    step(0, 1, 16'h0, "R3");
    step(1, 1, 16'h0C40, "R4");
    step(0, 1, 16'h0, "R6");
    step(0, 1, 16'h0, "R6");
    step(0, 1, 16'h0, "R7");
    step(1, 1, 16'h1234, "R4_no_ovr");
    for (int k = 0; k < 10; k++) step(0, 1, 16'(k * 4097), "R3_ring");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule